// File: doc/BRIEF.md
# Nested Power Rail Sequencer

This controller switches on four supply rails one at a time and later switches them off in the opposite order. A master enable starts the climb. Each rail enable opens a timed qualification window. The rail's power-good flag must be high when that window closes, otherwise the climb stops. The length of the window comes from an 8-bit delay code multiplied by a fixed number of clock cycles. At the default setting that is about 31.5 µs per code step, with a top value near 8.04 ms. The same spacing applies to every step, both going up and coming down.

Power-down starts in any of three cases: the master enable drops, a window fails, or the active-low fault line is pulled low. The controller first withdraws its chain-out handshake. It then waits until the downstream instance reports that its rails are gone. After that it removes its own rails from the highest down to the first, one per interval. A failed window pulls the active-low fault output low. That output is meant to be wire-ORed with other fault outputs onto a shared fault line.

Instances can be chained. The chain-out of one instance feeds the master enable of the next, and the next instance's enable-out returns as the busy input. After a fault, the controller stays off until the master enable has been seen low and then high again.

Top module: `rail_seq`

## Requirements
- R1: After the master enable has been sampled low, a clock edge that samples it high while the fault input is high sets rail enable bit 0 at that edge. The other bits follow one per interval in the order bit 1, bit 2, bit 3. The enable bits always form a contiguous run starting at bit 0.
- R2: One interval is max(N,1)×TICK_DIV clock cycles, where N is the unsigned 8-bit delay code. Every step uses this interval, in both the up and the down direction.
- R3: At the edge that closes a window, the power-good input of the newest rail is sampled. If it is high, the next rail is enabled at that same edge.
- R4: If that power-good input is low, `fault_n_o` goes low at that edge, power-down begins and no further rail is enabled. `fault_n_o` returns high at the edge that samples the master enable low.
- R5: Power-down clears the enable bits from the highest set bit down to bit 0. The first bit clears at the first edge after the trigger that samples `dn_busy_i` low, and each later bit clears one interval after the previous one.
- R6: While rising or fully on, the controller triggers power-down at the edge that samples either the master enable low or `fault_n_i` low. An external fault does not drive `fault_n_o` low.
- R7: `all_good_o` equals the AND of the four power-good inputs, one cycle later.
- R8: `en_out_o` is high from the edge that sets rail bit 0 until the edge that triggers power-down, and low at all other times.
- R9: `chain_out_o` rises one interval after bit 3 is enabled, provided rail 4's power-good is high. It falls at the edge that triggers power-down. While `dn_busy_i` stays high, the enable bits stay unchanged.
- R10: After a window failure or an external fault, no new climb starts until the master enable has been sampled low and then high. The same applies after reset.
- R11: Once power-down has begun, changes on the fault input and the power-good inputs have no effect on the remaining down steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Master enable |
| pg_i | input | 4 | Per-rail power-good flags, bit 0 = rail 1 |
| fault_n_i | input | 1 | Shared fault line, active low |
| dn_busy_i | input | 1 | Downstream instance still has rails on |
| delay_code_i | input | 8 | Interval code N |
| rail_en_o | output | 4 | Rail enables, bit 0 = rail 1 |
| all_good_o | output | 1 | AND of all power-good flags |
| fault_n_o | output | 1 | Window failure flag, active low (open-drain pull-down enable) |
| en_out_o | output | 1 | High while sequencing up or on |
| chain_out_o | output | 1 | Start signal for the downstream instance |

## Verification
Every output is registered. A decision taken from inputs sampled at one edge therefore shows up on the ports at that edge. The bench applies inputs at a falling edge and reads results at the next falling edge, so the first rail enable, a trigger and the end of a window are all checked exactly one cycle after they were applied or fell due. The next step is due exactly max(N,1)×TICK_DIV cycles after the previous enable change. The bench checks the port one cycle before that point, where it must be unchanged, and at that point, where it must have moved. The first down step is due one cycle after `dn_busy_i` is seen low, or two cycles after the trigger if the busy input was never high. The combined power-good output is checked one cycle after each new pattern.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RISE,
    S_HOLD,
    S_DRAIN,
    S_FALL
  } seq_state_t;
endpackage

// File: rtl/rseq_prescale.sv
// Divides the system clock down to one delay-code step.
module rseq_prescale #(
  parameter int TICK_DIV = 6306
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_count
      logic [PRE_W-1:0] pre_q;
      assign tick_o = (pre_q == PRE_W'(TICK_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end

      a_r2_pre_bound: assert property (@(posedge clk) disable iff (rst)
        32'(pre_q) < TICK_DIV);
    end
  endgenerate
endmodule

// File: rtl/rseq_interval.sv
// Counts one step interval in prescaler ticks; code 0 acts as 1.
module rseq_interval #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tick_i,
  output logic              done_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              run_q;

  assign done_o = run_q && tick_i && (cnt_q == CODE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= (code_i == '0) ? CODE_W'(1) : code_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CODE_W'(1)) run_q <= 1'b0;
    end
  end

  a_r2_count_live: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));
  a_r2_reload_full: assert property (@(posedge clk) disable iff (rst)
    $past(load_i) |-> (run_q && cnt_q != '0));
endmodule

// File: rtl/rseq_ctrl.sv
// Sequencing state machine: climb, hold, drain handshake, descent.
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int RAILS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [RAILS-1:0] pg_i,
  input  logic             fault_n_i,
  input  logic             dn_busy_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [RAILS-1:0] rail_o,
  output logic             fault_n_o,
  output logic             en_out_o,
  output logic             chain_o
);
  localparam int IDX_W = (RAILS > 1) ? $clog2(RAILS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RAILS - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [RAILS-1:0] rail_q;
  logic             arm_q, fault_n_q, en_out_q, chain_q;

  logic start, abort, qualified;

  assign start     = en_i && arm_q && fault_n_i;
  assign abort     = !en_i || !fault_n_i;
  assign qualified = pg_i[idx_q];

  always_comb begin
    load_o = 1'b0;
    unique case (state_q)
      S_IDLE:  load_o = start;
      S_RISE:  load_o = !abort && done_i && qualified && (idx_q != LAST);
      S_DRAIN: load_o = !dn_busy_i && (idx_q != '0);
      S_FALL:  load_o = done_i && (idx_q != '0);
      default: load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      rail_q    <= '0;
      arm_q     <= 1'b0;
      fault_n_q <= 1'b1;
      en_out_q  <= 1'b0;
      chain_q   <= 1'b0;
    end else begin
      if (!en_i) begin
        arm_q     <= 1'b1;
        fault_n_q <= 1'b1;
      end
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            rail_q    <= RAILS'(1);
            idx_q     <= '0;
            en_out_q  <= 1'b1;
            arm_q     <= 1'b0;
            state_q   <= S_RISE;
          end
        end
        S_RISE: begin
          if (abort) begin
            en_out_q <= 1'b0;
            arm_q    <= !en_i;
            state_q  <= S_DRAIN;
          end else if (done_i) begin
            if (!qualified) begin
              fault_n_q <= 1'b0;
              en_out_q  <= 1'b0;
              arm_q     <= 1'b0;
              state_q   <= S_DRAIN;
            end else if (idx_q == LAST) begin
              chain_q <= 1'b1;
              state_q <= S_HOLD;
            end else begin
              rail_q[idx_q + IDX_W'(1)] <= 1'b1;
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        S_HOLD: begin
          if (abort) begin
            chain_q  <= 1'b0;
            en_out_q <= 1'b0;
            arm_q    <= !en_i;
            state_q  <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (!dn_busy_i) begin
            rail_q[idx_q] <= 1'b0;
            if (idx_q == '0) state_q <= S_IDLE;
            else begin
              idx_q   <= idx_q - IDX_W'(1);
              state_q <= S_FALL;
            end
          end
        end
        S_FALL: begin
          if (done_i) begin
            rail_q[idx_q] <= 1'b0;
            if (idx_q == '0) state_q <= S_IDLE;
            else idx_q <= idx_q - IDX_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rail_o    = rail_q;
  assign fault_n_o = fault_n_q;
  assign en_out_o  = en_out_q;
  assign chain_o   = chain_q;

  a_r1_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((rail_q + RAILS'(1)) & rail_q) == '0);
  a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rail_q ^ $past(rail_q)) <= 1);
  a_r3_qualified_step: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == S_RISE && rail_q != $past(rail_q)) |->
      $past(done_i && pg_i[idx_q]));
  a_r5_paced_descent: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == S_FALL && rail_q != $past(rail_q)) |-> $past(done_i));
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == S_DRAIN && $past(dn_busy_i)) |-> $stable(rail_q));
  a_r9_chain_full: assert property (@(posedge clk) disable iff (rst)
    chain_q |-> (&rail_q && en_out_q));
  a_r4_fault_stops: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n_q) |-> !en_out_q && !chain_q);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (!en_out_q && rail_q == '0));
endmodule

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int RAILS    = 4,
  parameter int CODE_W   = 8,
  parameter int TICK_DIV = 6306
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [RAILS-1:0]  pg_i,
  input  logic              fault_n_i,
  input  logic              dn_busy_i,
  input  logic [CODE_W-1:0] delay_code_i,
  output logic [RAILS-1:0]  rail_en_o,
  output logic              all_good_o,
  output logic              fault_n_o,
  output logic              en_out_o,
  output logic              chain_out_o
);
  logic tick, load, done, good_q;

  rseq_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .clr_i(load), .tick_o(tick)
  );

  rseq_interval #(.CODE_W(CODE_W)) u_ivl (
    .clk(clk), .rst(rst), .load_i(load), .code_i(delay_code_i),
    .tick_i(tick), .done_o(done)
  );

  rseq_ctrl #(.RAILS(RAILS)) u_ctrl (
    .clk(clk), .rst(rst), .en_i(en_i), .pg_i(pg_i), .fault_n_i(fault_n_i),
    .dn_busy_i(dn_busy_i), .done_i(done), .load_o(load), .rail_o(rail_en_o),
    .fault_n_o(fault_n_o), .en_out_o(en_out_o), .chain_o(chain_out_o)
  );

  always_ff @(posedge clk) begin
    if (rst) good_q <= 1'b0;
    else     good_q <= &pg_i;
  end
  assign all_good_o = good_q;

  a_r7_all_good: assert property (@(posedge clk) disable iff (rst)
    all_good_o |-> $past(&pg_i));
endmodule

// File: tb/rail_seq_test.sv
`timescale 1ns/1ps
module rail_seq_test;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [3:0] pg_i = '0;
  logic       fault_n_i = 1'b1;
  logic       dn_busy_i = 1'b0;
  logic [7:0] delay_code_i = 8'd1;
  logic [3:0] rail_en_o;
  logic       all_good_o, fault_n_o, en_out_o, chain_out_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rail_seq #(.RAILS(4), .CODE_W(8), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .en_i(en_i), .pg_i(pg_i), .fault_n_i(fault_n_i),
    .dn_busy_i(dn_busy_i), .delay_code_i(delay_code_i), .rail_en_o(rail_en_o),
    .all_good_o(all_good_o), .fault_n_o(fault_n_o), .en_out_o(en_out_o),
    .chain_out_o(chain_out_o)
  );

  function automatic int ivl(input int code);
    return ((code == 0) ? 1 : code) * DIV;
  endfunction

  function automatic logic [3:0] therm(input int n);
    return 4'((1 << n) - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wneg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Power-down from n enabled rails; trigger applied at the current negedge.
  task automatic descend(input int n, input int busy, input int itv);
    dn_busy_i = (busy > 0);
    wneg(1);
    check("R8 en_out low on trigger", en_out_o, 0);
    check("R9 chain_out low on trigger", chain_out_o, 0);
    check("R5 no removal at trigger", rail_en_o, therm(n));
    if (busy > 0) begin
      wneg(busy - 1);
      check("R9 rails held while busy", rail_en_o, therm(n));
      dn_busy_i = 1'b0;
    end
    wneg(1);
    check("R5 top rail removed first", rail_en_o, therm(n - 1));
    for (int r = n - 1; r >= 1; r--) begin
      fault_n_i = 1'($urandom % 2);
      pg_i = 4'($urandom);
      wneg(itv - 1);
      check("R11 down step unaffected early", rail_en_o, therm(r));
      wneg(1);
      check("R2 R5 down step on interval", rail_en_o, therm(r - 1));
    end
    fault_n_i = 1'b1;
  endtask

  // mode 0: full climb then enable drop; 1: window failure; 2: external fault
  task automatic run_seq(input int code, input int mode, input int stop, input int busy);
    int itv;
    int n;
    itv = ivl(code);
    n = 4;
    pg_i = '0;
    en_i = 1'b0;
    delay_code_i = 8'(code);
    wneg(1);
    en_i = 1'b1;
    wneg(1);
    check("R1 rail 1 first", rail_en_o, 4'b0001);
    check("R8 en_out during climb", en_out_o, 1);
    for (int k = 0; k < 4; k++) begin
      if (mode == 2 && k == stop) begin
        fault_n_i = 1'b0;
        n = k + 1;
        break;
      end
      if (!(mode == 1 && k == stop)) pg_i[k] = 1'b1;
      wneg(itv - 1);
      check("R2 no step before interval", rail_en_o, therm(k + 1));
      wneg(1);
      if (mode == 1 && k == stop) begin
        check("R4 fault_n low on window failure", fault_n_o, 0);
        check("R4 no further rail", rail_en_o, therm(k + 1));
        check("R4 en_out low on failure", en_out_o, 0);
        n = k + 1;
        break;
      end else if (k < 3) begin
        check("R1 R3 next rail on interval", rail_en_o, therm(k + 2));
      end else begin
        check("R9 chain_out after rail 4", chain_out_o, 1);
        check("R7 all_good with all rails good", all_good_o, 1);
      end
    end
    if (mode == 1) begin
      dn_busy_i = 1'b0;
      wneg(1);
      check("R5 removal after failure", rail_en_o, therm(n - 1));
      for (int r = n - 1; r >= 1; r--) begin
        wneg(itv - 1);
        check("R5 down wait", rail_en_o, therm(r));
        wneg(1);
        check("R5 down step", rail_en_o, therm(r - 1));
      end
    end else begin
      if (mode == 0) en_i = 1'b0;
      if (mode == 2) begin
        descend(n, busy, itv);
        check("R6 external fault leaves fault_n high", fault_n_o, 1);
      end else begin
        descend(n, busy, itv);
      end
    end
    if (mode != 0) begin
      fault_n_i = 1'b1;
      wneg(2 * itv + 2);
      check("R10 no restart after fault", rail_en_o, 0);
      check("R4 fault_n latched state", fault_n_o, (mode == 1) ? 0 : 1);
      en_i = 1'b0;
      wneg(1);
      check("R4 fault_n cleared by enable low", fault_n_o, 1);
    end else begin
      check("R6 enable drop leaves fault_n high", fault_n_o, 1);
    end
    pg_i = '0;
    wneg(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    en_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset en_out", en_out_o, 0);
    check("R4 reset fault_n", fault_n_o, 1);
    check("R9 reset chain_out", chain_out_o, 0);
    wneg(10);
    check("R10 no start with enable held from reset", rail_en_o, 0);
    en_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [3:0] p;
      p = (i == 0) ? 4'hF : 4'($urandom);
      pg_i = p;
      wneg(1);
      check("R7 all_good AND", all_good_o, &p);
    end
    run_seq(0, 0, 0, 0);
    run_seq(2, 0, 0, 3);
    run_seq(255, 1, 3, 0);
    run_seq(1, 2, 0, 1);
    for (int t = 0; t < 14; t++)
      run_seq(int'($urandom % 6), int'($urandom % 3), int'($urandom % 4),
              int'($urandom % 4));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule